// File: doc/BRIEF.md
# Line-Buffered Raster Scan Controller

This block produces a 640 by 480 raster with active-low horizontal and vertical sync and paints it from a single-line store instead of a whole frame store. A host refills the store one row at a time. Each 32-bit word holds four one-byte pixels. Each byte is split into a 3-bit red field, a 3-bit green field and a 2-bit blue field, which drive the colour outputs directly.

When the scan finishes the visible columns of a visible line, the block pulses `line_irq` for one clock and sets a sticky `irq_flag` that stays up until the host pulses `irq_ack`. `next_row` tells the host which image row it must load next, so its software cannot drift out of step with the beam. With `interlace_en` set, frames alternate between even rows and odd rows. Only lines of the current frame's parity request a refill, so each loaded row is shown on two consecutive scan lines.

The host write port is a valid/ready stream. `wr_ready` is held high at all times, so the block never applies back-pressure, and a word is stored on every clock in which `wr_valid` is high. The write port is not gated by reset, so the host may preload the store while the scan logic is held in reset. The host is expected to write during horizontal blanking, after the request. If a word is written at the same address and in the same clock as it is read, the read returns the old word.

Top module: `vga_line_scan`

## Requirements
- R1: While `rst_n` is low, the colour outputs are 0, `hsync_n` and `vsync_n` are high, `line_irq` and `irq_flag` are 0, and `next_row` is 0.
- R2: A line lasts H_VIS+H_FP+H_SY+H_BP clocks. `hsync_n` is low for exactly H_SY clocks, starting at column H_VIS+H_FP.
- R3: A frame lasts V_VIS+V_FP+V_SY+V_BP lines and then wraps to line 0. `vsync_n` is low for the whole of lines V_VIS+V_FP through V_VIS+V_FP+V_SY-1.
- R4: The pixel at visible column x is taken from store word x/4. Byte x%4 is used, where byte 0 is bits [31:24] and byte 3 is bits [7:0]. From that byte, red is bits [7:5], green is bits [4:2] and blue is bits [1:0].
- R5: Colour and both syncs describe the counter position of two clocks earlier, all on the same clock.
- R6: Colour is 0 at every position outside the 640 by 480 visible area.
- R7: `line_irq` is high for exactly one clock. That is the clock in which the scan counter is at column H_VIS of a visible line that requests a refill. With `interlace_en` low, every visible line requests one.
- R8: With `interlace_en` low, `next_row` becomes v+1 in the clock of the pulse for row v, and 0 after row V_VIS-1. It does not change in any other clock.
- R9: Frame 0 after reset is even, and the parity flips at every frame wrap. With `interlace_en` high, only rows of the frame's parity pulse. After row v, `next_row` becomes v+2, or the first row of the opposite parity when v+2 reaches V_VIS.
- R10: `irq_flag` rises with `line_irq` and falls on the clock after `irq_ack` is high. When a pulse and an acknowledge coincide, the flag stays set.
- R11: A word on `wr_data` is stored at `wr_addr` only when `wr_valid` is high. `wr_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset of the scan logic |
| interlace_en | input | 1 | Selects alternating-parity frames |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Always high, no back-pressure |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | 32 | Four packed pixels, pixel 0 in the top byte |
| irq_ack | input | 1 | Clears the sticky request flag |
| line_irq | output | 1 | One-clock refill request |
| irq_flag | output | 1 | Sticky refill request |
| next_row | output | ROW_W | Image row the host must load next |
| red | output | 3 | Red level |
| green | output | 3 | Green level |
| blue | output | 2 | Blue level |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench shrinks the raster and drives a recognisable word in which every colour field differs. A design that reversed the byte order or shifted the field boundaries would show swapped or smeared colours. It compares every clock against a model delayed by two stages, so a colour path one stage shorter than the sync path shows up as a one-pixel skew. Coinciding acknowledges and requests, writes with `wr_valid` low carrying junk data, and the wrap of `next_row` at the last row in both progressive and interlaced frames are each exercised. A tracker that restarted an interlaced frame on the wrong parity would request the wrong rows.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int PIX_W = 8;

  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [1:0] b;
  } vls_pix_t;

  // Split one stored byte into its colour fields
  function automatic vls_pix_t unpack_pix(input logic [PIX_W-1:0] raw);
    vls_pix_t p;
    p.r = raw[7:5];
    p.g = raw[4:2];
    p.b = raw[1:0];
    return p;
  endfunction
endpackage

// File: rtl/vls_timing.sv
module vls_timing #(
  parameter int H_VIS = 640,
  parameter int H_FP  = 16,
  parameter int H_SY  = 96,
  parameter int H_BP  = 48,
  parameter int V_VIS = 480,
  parameter int V_FP  = 10,
  parameter int V_SY  = 2,
  parameter int V_BP  = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SY + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          in_view,
  output logic          hs_on,
  output logic          vs_on,
  output logic          line_end,
  output logic          frame_end
);
  localparam int HS_LO = H_VIS + H_FP;
  localparam int HS_HI = HS_LO + H_SY;
  localparam int VS_LO = V_VIS + V_FP;
  localparam int VS_HI = VS_LO + V_SY;

  logic h_last, v_last;
  assign h_last = (h_cnt == HW'(H_TOT - 1));
  assign v_last = (v_cnt == VW'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_last) begin
      h_cnt <= '0;
      v_cnt <= v_last ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  assign in_view   = (int'(h_cnt) < H_VIS) && (int'(v_cnt) < V_VIS);
  assign hs_on     = (int'(h_cnt) >= HS_LO) && (int'(h_cnt) < HS_HI);
  assign vs_on     = (int'(v_cnt) >= VS_LO) && (int'(v_cnt) < VS_HI);
  assign line_end  = (h_cnt == HW'(H_VIS - 1)) && (int'(v_cnt) < V_VIS);
  assign frame_end = h_last && v_last;
endmodule

// File: rtl/vls_line_ram.sv
module vls_line_ram #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Registered read; a same-cycle write to the same word is not seen
  always_ff @(posedge clk) begin
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/vls_row_tracker.sv
module vls_row_tracker #(
  parameter int V_VIS = 480,
  parameter int VW    = 10,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             interlace_en,
  input  logic             line_end,
  input  logic             frame_end,
  input  logic [VW-1:0]    v_cnt,
  input  logic             irq_ack,
  output logic             irq_pulse,
  output logic             irq_sticky,
  output logic [ROW_W-1:0] row_q
);
  logic frame_odd;
  logic fire;
  int   nxt;

  assign fire = line_end && (!interlace_en || (v_cnt[0] == frame_odd));

  always_comb begin
    if (!interlace_en)
      nxt = (int'(v_cnt) == V_VIS - 1) ? 0 : int'(v_cnt) + 1;
    else if (int'(v_cnt) + 2 >= V_VIS)
      nxt = frame_odd ? 0 : 1;
    else
      nxt = int'(v_cnt) + 2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_odd  <= 1'b0;
      irq_pulse  <= 1'b0;
      irq_sticky <= 1'b0;
      row_q      <= '0;
    end else begin
      irq_pulse <= fire;
      if (frame_end) frame_odd <= ~frame_odd;
      if (fire) begin
        row_q      <= ROW_W'(nxt);
        irq_sticky <= 1'b1;
      end else if (irq_ack) begin
        irq_sticky <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vga_line_scan.sv
module vga_line_scan #(
  parameter int H_VIS     = 640,
  parameter int H_FP      = 16,
  parameter int H_SY      = 96,
  parameter int H_BP      = 48,
  parameter int V_VIS     = 480,
  parameter int V_FP      = 10,
  parameter int V_SY      = 2,
  parameter int V_BP      = 33,
  parameter int BUF_WORDS = 256,
  parameter int DATA_W    = 32,
  localparam int ADDR_W = $clog2(BUF_WORDS),
  localparam int ROW_W  = $clog2(V_VIS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              interlace_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_ack,
  output logic              line_irq,
  output logic              irq_flag,
  output logic [ROW_W-1:0]  next_row,
  output logic [2:0]        red,
  output logic [2:0]        green,
  output logic [1:0]        blue,
  output logic              hsync_n,
  output logic              vsync_n
);
  import vls_pkg::*;

  localparam int H_TOT = H_VIS + H_FP + H_SY + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int PPW   = DATA_W / PIX_W;
  localparam int SEL_W = $clog2(PPW);

  logic [HW-1:0]     h_cnt;
  logic [VW-1:0]     v_cnt;
  logic              in_view, hs_on, vs_on, line_end, frame_end;
  logic [HW-1:0]     word_idx;
  logic [DATA_W-1:0] rd_word;

  vls_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .in_view(in_view), .hs_on(hs_on), .vs_on(vs_on),
    .line_end(line_end), .frame_end(frame_end)
  );

  assign wr_ready = 1'b1;
  assign word_idx = h_cnt >> SEL_W;

  vls_line_ram #(.WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .wr_en(wr_valid && wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ADDR_W'(word_idx)), .rd_data(rd_word)
  );

  vls_row_tracker #(.V_VIS(V_VIS), .VW(VW), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .interlace_en(interlace_en),
    .line_end(line_end), .frame_end(frame_end), .v_cnt(v_cnt),
    .irq_ack(irq_ack), .irq_pulse(line_irq), .irq_sticky(irq_flag),
    .row_q(next_row)
  );

  // Stage 1 matches the store's read latency; stage 2 drives the pins
  logic             s1_vis, s1_hs, s1_vs;
  logic [SEL_W-1:0] s1_sel;
  vls_pix_t         pix_q;
  logic             hs_q, vs_q;
  logic [PIX_W-1:0] raw_byte;

  assign raw_byte = rd_word[(PPW - 1 - int'(s1_sel)) * PIX_W +: PIX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vis <= 1'b0;
      s1_hs  <= 1'b0;
      s1_vs  <= 1'b0;
      s1_sel <= '0;
      pix_q  <= '0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
    end else begin
      s1_vis <= in_view;
      s1_hs  <= hs_on;
      s1_vs  <= vs_on;
      s1_sel <= h_cnt[SEL_W-1:0];
      pix_q  <= s1_vis ? unpack_pix(raw_byte) : '0;
      hs_q   <= s1_hs;
      vs_q   <= s1_vs;
    end
  end

  assign red     = pix_q.r;
  assign green   = pix_q.g;
  assign blue    = pix_q.b;
  assign hsync_n = ~hs_q;
  assign vsync_n = ~vs_q;
endmodule

// File: rtl/vga_line_scan_chk.sv
module vga_line_scan_chk #(
  parameter int V_VIS = 480,
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_ack,
  input logic             line_irq,
  input logic             irq_flag,
  input logic [ROW_W-1:0] next_row,
  input logic [2:0]       red,
  input logic [2:0]       green,
  input logic [1:0]       blue,
  input logic             hsync_n,
  input logic             vsync_n
);
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |=> !line_irq);

  p_flag_follows_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> irq_flag);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_ack) && !line_irq) |-> !irq_flag);

  p_hblank_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> ({red, green, blue} == 8'h00));

  p_vblank_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> ({red, green, blue} == 8'h00));

  p_row_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(next_row) < V_VIS);

  p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_irq |-> $stable(next_row));
endmodule

bind vga_line_scan vga_line_scan_chk #(.V_VIS(V_VIS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .line_irq(line_irq),
  .irq_flag(irq_flag), .next_row(next_row), .red(red), .green(green),
  .blue(blue), .hsync_n(hsync_n), .vsync_n(vsync_n)
);

// File: tb/vga_line_scan_test.sv
module vga_line_scan_test;
  localparam int H_VIS = 16, H_FP = 2, H_SY = 3, H_BP = 3;
  localparam int V_VIS = 6,  V_FP = 1, V_SY = 2, V_BP = 1;
  localparam int H_TOT = H_VIS + H_FP + H_SY + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP;
  localparam int WORDS = 8;
  localparam int AW = $clog2(WORDS);
  localparam int RW = $clog2(V_VIS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interlace_en = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic irq_ack = 1'b0;
  logic line_irq, irq_flag;
  logic [RW-1:0] next_row;
  logic [2:0] red, green;
  logic [1:0] blue;
  logic hsync_n, vsync_n;

  always #10 clk = ~clk;

  vga_line_scan #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SY(H_SY), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP),
    .BUF_WORDS(WORDS), .DATA_W(32)
  ) uut (
    .clk(clk), .rst_n(rst_n), .interlace_en(interlace_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack(irq_ack), .line_irq(line_irq),
    .irq_flag(irq_flag), .next_row(next_row), .red(red), .green(green),
    .blue(blue), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  int n_vec = 0, n_bad = 0;
  logic [31:0] mem_m [WORDS];
  int mh, mv, mpar, m_next;
  logic m_irq, m_flag;
  logic [9:0] pipe1, pipe2; // {hs_n, vs_n, byte}
  int pend;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // Expected pins for a counter position, per R2, R3, R4, R6
  function automatic logic [9:0] expect_at(input int h, input int v);
    logic [7:0] b;
    logic hs, vs;
    b = 8'h00;
    if (h < H_VIS && v < V_VIS) b = mem_m[h / 4][(3 - h % 4) * 8 +: 8];
    hs = !(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SY);
    vs = !(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SY);
    return {hs, vs, b};
  endfunction

  task automatic model_reset();
    mh = 0; mv = 0; mpar = 0; m_next = 0;
    m_irq = 0; m_flag = 0; pend = 0;
    pipe1 = 10'h300; pipe2 = 10'h300;
  endtask

  task automatic check_reset_state();
    check("R1 colour", {red, green, blue}, 0);
    check("R1 hsync_n", hsync_n, 1);
    check("R1 vsync_n", vsync_n, 1);
    check("R1 line_irq", line_irq, 0);
    check("R1 irq_flag", irq_flag, 0);
    check("R1 next_row", next_row, 0);
  endtask

  // One clock: check pins at negedge, drive inputs, advance the model
  task automatic step();
    logic [9:0] now;
    bit fire;
    string rq;
    rq = interlace_en ? "R9" : "R7";
    check((pipe2[9] && pipe2[8] && pipe2[7:0] != 0) ? "R4/R5 colour" : "R6/R4 colour",
          {red, green, blue}, pipe2[7:0]);
    check("R2/R5 hsync_n", hsync_n, pipe2[9]);
    check("R3/R5 vsync_n", vsync_n, pipe2[8]);
    check({rq, " line_irq"}, line_irq, m_irq);
    check(interlace_en ? "R9 next_row" : "R8 next_row", next_row, m_next);
    check("R10 irq_flag", irq_flag, m_flag);
    check("R11 wr_ready", wr_ready, 1);

    if (m_irq) pend = 4;
    irq_ack = ($urandom_range(0, 3) == 0);
    if (pend > 0) begin
      wr_valid = 1'b1;
      wr_addr  = AW'(4 - pend);
      wr_data  = $urandom();
      pend--;
    end else begin
      // R11: junk on the bus with wr_valid low must not land
      wr_valid = 1'b0;
      wr_addr  = AW'($urandom_range(0, 3));
      wr_data  = $urandom();
    end

    now = expect_at(mh, mv);
    pipe2 = pipe1;
    pipe1 = now;
    fire = (mh == H_VIS - 1) && (mv < V_VIS) && (!interlace_en || (mv % 2) == mpar);
    m_irq = fire;
    if (fire) begin
      if (!interlace_en) m_next = (mv == V_VIS - 1) ? 0 : mv + 1;
      else m_next = (mv + 2 >= V_VIS) ? 1 - mpar : mv + 2;
      m_flag = 1'b1;
    end else if (irq_ack) begin
      m_flag = 1'b0;
    end
    if (wr_valid) mem_m[wr_addr] = wr_data;
    if (mh == H_TOT - 1) begin
      mh = 0;
      if (mv == V_TOT - 1) begin
        mv = 0;
        mpar = 1 - mpar;
      end else mv++;
    end else mh++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic preload(input logic [31:0] w0, input logic [31:0] w1);
    for (int i = 0; i < WORDS; i++) begin
      wr_valid = 1'b1;
      wr_addr  = AW'(i);
      wr_data  = (i == 0) ? w0 : (i == 1) ? w1 : $urandom();
      mem_m[i] = wr_data;
      @(posedge clk);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    // Directed R4 pattern: every field of every byte differs
    preload(32'hE01C03A5, 32'h5AFF0049);
    check_reset_state();
    model_reset();
    rst_n = 1'b1;
    for (int c = 0; c < 3 * H_TOT * V_TOT; c++) step();

    // R9: interlaced frames after a fresh reset
    rst_n = 1'b0;
    interlace_en = 1'b1;
    irq_ack = 1'b1; // R10: ack during reset leaves flag low
    @(posedge clk);
    @(negedge clk);
    check_reset_state();
    irq_ack = 1'b0;
    model_reset();
    rst_n = 1'b1;
    for (int c = 0; c < 4 * H_TOT * V_TOT; c++) step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule